// File: doc/BRIEF.md
# I2C Target Byte Engine with Clock-Hold Handshake

This block is the target side of a two-wire serial bus. It finds START and STOP conditions, compares the first byte after a START with a 7-bit own address, and keeps the read/write bit of a matching byte. It then moves data one byte at a time in either direction. After every byte it keeps its address, including the address byte itself, it pulls SCL low and raises an interrupt. The clock stays low until the host accesses the data register. The host can write the next byte to send, read the byte that arrived, or make a dummy read.

The host drives the transfer through a small register port. There are strobes to write and to read the data register, a write for the transmit/receive mode bit, and a write for the acknowledge-disable control. The block returns an address-hit flag, the latched read/write bit, the acknowledge bit sampled from the controller, and the interrupt. On both bus lines the block only pulls low or lets go, and it never drives a line high. Both lines pass through a synchronizer before any edge is used.

Top module: `i2c_hold_slave`

## Requirements
- R1: After reset both bus outputs are released (scl_oe = 0, sda_oe = 0), and irq, addr_hit, tx_mode and ack_dis are all 0.
- R2: A byte after START whose upper seven bits equal own_addr is acknowledged: SDA is held low during the ninth SCL clock. After the ninth falling edge SCL is held low, and addr_hit and irq go to 1. rw_bit takes the byte's lowest bit (1 = controller reads).
- R3: A byte after START that does not match own_addr gets no acknowledge. SCL is not held and addr_hit stays 0. Every following byte is ignored until the next START.
- R4: While SCL is held, it stays held until a data-register write (host_wr_en) or read (host_rd_en). That access releases SCL and clears irq and addr_hit. SCL is only ever held while irq is 1.
- R5: In receive mode, bits are sampled MSB first on SCL rising edges. After the ninth falling edge SCL is held, irq is 1, and host_rdata shows the received byte.
- R6: In receive mode the block pulls SDA low during the ninth clock when ack_dis = 0 and leaves SDA released when ack_dis = 1. ack_dis is taken at the eighth falling edge.
- R7: When tx_mode = 1, a data-register write during a hold loads the byte. The byte is shifted out MSB first, and SDA changes only while SCL is low. SDA is released during the ninth clock.
- R8: In transmit mode rx_ack takes SDA on the ninth rising edge (0 = ACK, 1 = NACK), and SCL is then held.
- R9: A STOP (SDA rising while SCL is high) returns the block to idle. It releases both lines, clears tx_mode and irq, and wins over a mode write in the same cycle.
- R10: A START seen in any state, including a repeated START in the middle of a transfer, restarts address reception.
- R11: SCL and SDA are never pulled low by the block at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| own_addr | input | 7 | Target address to match |
| host_wr_en | input | 1 | Data-register write strobe |
| host_wdata | input | 8 | Byte written to the data register |
| host_rd_en | input | 1 | Data-register read strobe (also the dummy read) |
| host_rdata | output | 8 | Last received byte |
| mode_we | input | 1 | Write strobe for the mode bit |
| mode_tx | input | 1 | Mode value: 1 transmit, 0 receive |
| ackdis_we | input | 1 | Write strobe for the acknowledge-disable control |
| ackdis_val | input | 1 | 1 suppresses the target's acknowledge |
| tx_mode | output | 1 | Current mode bit |
| ack_dis | output | 1 | Current acknowledge-disable control |
| addr_hit | output | 1 | Address-match flag |
| rw_bit | output | 1 | Read/write bit of the matched address byte |
| rx_ack | output | 1 | Acknowledge bit sampled from the controller |
| irq | output | 1 | Pending-byte interrupt |

## Verification
The assertions check four things on every cycle: the clock hold only ever comes with a pending interrupt, the hold ends on a data-register access and on nothing else, a STOP leaves both lines free with transmit mode cleared, and the block never pulls both lines low together. They also check that the SDA output changes only while the synchronized SCL is low, unless a STOP has just been seen. Only the bench scenarios can show the data path end to end. These are the full address sweep with exactly one acknowledged value, every receive byte value with the acknowledge suppressed on selected bytes, and a multi-byte transmit sequence that ends on a controller NACK. They also cover a repeated START and a STOP in the middle of a byte.

// File: rtl/i2c_hold_pkg.sv
// Shared types for the clock-hold I2C target.
// Assumes: one target engine per bus, 7-bit addressing only.
package i2c_hold_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,   // waiting for START
        ST_ADDR,   // shifting in the address byte
        ST_AACK,   // pulling SDA low for the address acknowledge
        ST_HOLD,   // holding SCL low until the host touches the data register
        ST_RX,     // shifting in a data byte
        ST_RACK,   // ninth clock of a received byte
        ST_TX,     // shifting out a data byte
        ST_TACK,   // ninth clock of a sent byte, controller answers
        ST_SKIP    // address did not match, wait for START or STOP
    } eng_state_t;

endpackage

// File: rtl/i2c_line_sync.sv
// Synchronizer and edge detector for one open-drain bus line.
// Assumes: the line idles high; STAGES >= 2 flops before any use.
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);

    logic [STAGES-1:0] chain;
    logic              prev;

    // Shift the raw line through the flop chain; reset to the idle-high level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '1;
            prev  <= 1'b1;
        end else begin
            chain <= {chain[STAGES-2:0], line_i};
            prev  <= chain[STAGES-1];
        end
    end

    // Level and single-cycle edge pulses from the synchronized value.
    always_comb begin
        level_o = chain[STAGES-1];
        rise_o  = chain[STAGES-1] & ~prev;
        fall_o  = ~chain[STAGES-1] & prev;
    end

endmodule

// File: rtl/i2c_cond_detect.sv
// Finds START and STOP conditions on the synchronized lines.
// Assumes: both lines pass through synchronizers of the same depth, so an
// SDA edge with SCL high and not just rising is a bus condition.
module i2c_cond_detect (
    input  logic scl_lvl,
    input  logic scl_rise,
    input  logic sda_rise,
    input  logic sda_fall,
    output logic start_o,
    output logic stop_o
);

    // SDA falls with SCL steadily high: START; SDA rises: STOP.
    always_comb begin
        start_o = sda_fall & scl_lvl & ~scl_rise;
        stop_o  = sda_rise & scl_lvl & ~scl_rise;
    end

endmodule

// File: rtl/i2c_host_ctrl.sv
// Host-written control bits: transmit mode and acknowledge disable.
// Assumes: a STOP on the bus has priority over a host write of the mode.
module i2c_host_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_we,
    input  logic mode_d,
    input  logic ackdis_we,
    input  logic ackdis_d,
    input  logic stop_det,
    output logic tx_mode,
    output logic ack_dis
);

    // Mode bit: host writes it, a STOP clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)        tx_mode <= 1'b0;
        else if (stop_det) tx_mode <= 1'b0;
        else if (mode_we)  tx_mode <= mode_d;
    end

    // Acknowledge-disable control: host-written only.
    always_ff @(posedge clk) begin
        if (!rst_n)         ack_dis <= 1'b0;
        else if (ackdis_we) ack_dis <= ackdis_d;
    end

endmodule

// File: rtl/i2c_byte_engine.sv
// Byte engine of the target: address compare, shifting in and out, ninth-clock
// handling, and the SCL hold after every byte it takes part in.
// Assumes: synchronized SCL edges come as single-cycle pulses; the SDA output
// is registered and updated only on SCL falling edges or during a hold.
module i2c_byte_engine
    import i2c_hold_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_lvl,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [DATA_W-2:0] own_addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              tx_mode,
    input  logic              ack_dis,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic [DATA_W-1:0] rx_byte,
    output logic              addr_hit,
    output logic              rw_bit,
    output logic              rx_ack,
    output logic              irq
);

    localparam int CW = $clog2(DATA_W + 1);
    localparam logic [CW-1:0] LAST = CW'(DATA_W);

    eng_state_t        st;
    logic [DATA_W-1:0] sh;
    logic [CW-1:0]     cnt;
    logic              sda_q;
    logic              access;

    // Any data-register access ends a hold.
    always_comb access = wr_en | rd_en;

    // Main sequencer: bus conditions first, then the per-state byte handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            sh       <= '0;
            cnt      <= '0;
            sda_q    <= 1'b0;
            rx_byte  <= '0;
            addr_hit <= 1'b0;
            rw_bit   <= 1'b0;
            rx_ack   <= 1'b0;
            irq      <= 1'b0;
        end else if (stop_det) begin
            st       <= ST_IDLE;
            cnt      <= '0;
            sda_q    <= 1'b0;
            irq      <= 1'b0;
            addr_hit <= 1'b0;
        end else if (start_det) begin
            st       <= ST_ADDR;
            cnt      <= '0;
            sda_q    <= 1'b0;
            irq      <= 1'b0;
            addr_hit <= 1'b0;
        end else begin
            case (st)
                ST_ADDR: begin
                    if (scl_rise) begin
                        sh  <= {sh[DATA_W-2:0], sda_lvl};
                        cnt <= cnt + 1'b1;
                    end else if (scl_fall && cnt == LAST) begin
                        cnt <= '0;
                        if (sh[DATA_W-1:1] == own_addr) begin
                            st     <= ST_AACK;
                            sda_q  <= 1'b1;
                            rw_bit <= sh[0];
                        end else begin
                            st <= ST_SKIP;
                        end
                    end
                end
                ST_AACK: begin
                    if (scl_fall) begin
                        st       <= ST_HOLD;
                        sda_q    <= 1'b0;
                        irq      <= 1'b1;
                        addr_hit <= 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (access) begin
                        irq      <= 1'b0;
                        addr_hit <= 1'b0;
                        cnt      <= '0;
                        if (tx_mode && wr_en) begin
                            st    <= ST_TX;
                            sh    <= wr_data;
                            sda_q <= ~wr_data[DATA_W-1];
                        end else begin
                            st <= ST_RX;
                        end
                    end
                end
                ST_RX: begin
                    if (scl_rise) begin
                        sh  <= {sh[DATA_W-2:0], sda_lvl};
                        cnt <= cnt + 1'b1;
                    end else if (scl_fall && cnt == LAST) begin
                        st      <= ST_RACK;
                        rx_byte <= sh;
                        sda_q   <= ~ack_dis;
                        cnt     <= '0;
                    end
                end
                ST_RACK: begin
                    if (scl_fall) begin
                        st    <= ST_HOLD;
                        sda_q <= 1'b0;
                        irq   <= 1'b1;
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        cnt <= cnt + 1'b1;
                    end else if (scl_fall) begin
                        if (cnt == LAST) begin
                            st    <= ST_TACK;
                            sda_q <= 1'b0;
                            cnt   <= '0;
                        end else begin
                            sh    <= {sh[DATA_W-2:0], 1'b0};
                            sda_q <= ~sh[DATA_W-2];
                        end
                    end
                end
                ST_TACK: begin
                    if (scl_rise) begin
                        rx_ack <= sda_lvl;
                    end else if (scl_fall) begin
                        st  <= ST_HOLD;
                        irq <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Open-drain controls: SCL is held only in the hold state.
    always_comb begin
        scl_oe = (st == ST_HOLD);
        sda_oe = sda_q;
    end

endmodule

// File: rtl/i2c_hold_slave.sv
// Top of the clock-hold I2C target: line synchronizers, condition detector,
// host control bits and the byte engine.
// Assumes: external pull-ups; the *_oe outputs drive an open-drain pad
// (1 = pull low, 0 = release).
module i2c_hold_slave #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic [DATA_W-2:0] own_addr,
    input  logic              host_wr_en,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_rd_en,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              mode_we,
    input  logic              mode_tx,
    input  logic              ackdis_we,
    input  logic              ackdis_val,
    output logic              tx_mode,
    output logic              ack_dis,
    output logic              addr_hit,
    output logic              rw_bit,
    output logic              rx_ack,
    output logic              irq
);

    localparam int NLINES = 2;  // index 0: SCL, index 1: SDA

    logic [NLINES-1:0] raw;
    logic [NLINES-1:0] lvl;
    logic [NLINES-1:0] rise;
    logic [NLINES-1:0] fall;
    logic              scl_lvl;
    logic              start_det;
    logic              stop_det;

    // Gather both raw line levels into one vector.
    always_comb raw = {sda_i, scl_i};

    // One synchronizer per bus line.
    for (genvar g = 0; g < NLINES; g++) begin : g_sync
        i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .line_i  (raw[g]),
            .level_o (lvl[g]),
            .rise_o  (rise[g]),
            .fall_o  (fall[g])
        );
    end

    // Name the synchronized SCL level for readability and for the checker.
    always_comb scl_lvl = lvl[0];

    i2c_cond_detect u_cond (
        .scl_lvl  (scl_lvl),
        .scl_rise (rise[0]),
        .sda_rise (rise[1]),
        .sda_fall (fall[1]),
        .start_o  (start_det),
        .stop_o   (stop_det)
    );

    i2c_host_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_we   (mode_we),
        .mode_d    (mode_tx),
        .ackdis_we (ackdis_we),
        .ackdis_d  (ackdis_val),
        .stop_det  (stop_det),
        .tx_mode   (tx_mode),
        .ack_dis   (ack_dis)
    );

    i2c_byte_engine #(.DATA_W(DATA_W)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (rise[0]),
        .scl_fall  (fall[0]),
        .sda_lvl   (lvl[1]),
        .start_det (start_det),
        .stop_det  (stop_det),
        .own_addr  (own_addr),
        .wr_en     (host_wr_en),
        .wr_data   (host_wdata),
        .rd_en     (host_rd_en),
        .tx_mode   (tx_mode),
        .ack_dis   (ack_dis),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe),
        .rx_byte   (host_rdata),
        .addr_hit  (addr_hit),
        .rw_bit    (rw_bit),
        .rx_ack    (rx_ack),
        .irq       (irq)
    );

endmodule

// File: rtl/i2c_hold_slave_chk.sv
// Protocol checker for the clock-hold I2C target, bound into the top module.
// Assumes: access to the top's synchronized SCL level and STOP pulse.
module i2c_hold_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_oe,
    input logic sda_oe,
    input logic irq,
    input logic addr_hit,
    input logic host_wr_en,
    input logic host_rd_en,
    input logic tx_mode,
    input logic stop_det,
    input logic scl_lvl
);

    // R4: a clock hold always comes with a pending interrupt.
    p_hold_needs_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        scl_oe |-> irq);

    // R4: a data-register access during a hold frees SCL on the next cycle.
    p_access_frees_r4: assert property (@(posedge clk) disable iff (!rst_n)
        scl_oe && (host_wr_en || host_rd_en) |=> !scl_oe);

    // R4: without an access the hold persists.
    p_hold_persists_r4: assert property (@(posedge clk) disable iff (!rst_n)
        scl_oe && !host_wr_en && !host_rd_en |=> scl_oe);

    // R2: the address flag never rises without the interrupt.
    p_hit_with_irq_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_hit) |-> irq);

    // R9: a STOP leaves both lines free and transmit mode cleared.
    p_stop_idles_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !tx_mode && !scl_oe && !sda_oe);

    // R7: SDA output moves only while SCL is low, except on a STOP.
    p_sda_moves_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_lvl || $past(stop_det));

    // R11: never both lines pulled low at once.
    p_one_line_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(scl_oe && sda_oe));

endmodule

bind i2c_hold_slave i2c_hold_slave_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_oe     (scl_oe),
    .sda_oe     (sda_oe),
    .irq        (irq),
    .addr_hit   (addr_hit),
    .host_wr_en (host_wr_en),
    .host_rd_en (host_rd_en),
    .tx_mode    (tx_mode),
    .stop_det   (stop_det),
    .scl_lvl    (scl_lvl)
);

// File: tb/i2c_hold_slave_test.sv
// Bench: a bus controller model and a host model drive the target through
// an address sweep, an all-values receive sweep, a transmit sequence, a STOP
// in the middle of a byte and a repeated START.
module i2c_hold_slave_test;

    localparam int H = 10;               // half SCL period in clk cycles
    localparam logic [6:0] OWN = 7'h5A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl_low = 1'b0;
    logic       m_sda_low = 1'b0;
    logic       scl_line, sda_line;
    logic       scl_oe, sda_oe;
    logic       host_wr_en = 1'b0, host_rd_en = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       mode_we = 1'b0, mode_tx = 1'b0;
    logic       ackdis_we = 1'b0, ackdis_val = 1'b0;
    logic       tx_mode, ack_dis, addr_hit, rw_bit, rx_ack, irq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    assign scl_line = ~(m_scl_low | scl_oe);
    assign sda_line = ~(m_sda_low | sda_oe);

    i2c_hold_slave uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(OWN),
        .host_wr_en(host_wr_en), .host_wdata(host_wdata),
        .host_rd_en(host_rd_en), .host_rdata(host_rdata),
        .mode_we(mode_we), .mode_tx(mode_tx),
        .ackdis_we(ackdis_we), .ackdis_val(ackdis_val),
        .tx_mode(tx_mode), .ack_dis(ack_dis), .addr_hit(addr_hit),
        .rw_bit(rw_bit), .rx_ack(rx_ack), .irq(irq)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // ---- controller model ----
    task automatic bus_start();
        m_sda_low = 1'b0; waitc(H);
        m_scl_low = 1'b0; waitc(H);
        m_sda_low = 1'b1; waitc(H);
        m_scl_low = 1'b1; waitc(H);
    endtask

    task automatic bus_stop();
        m_sda_low = 1'b1; waitc(H);
        m_scl_low = 1'b0; waitc(H);
        m_sda_low = 1'b0; waitc(H);
    endtask

    task automatic put_bit(input bit b);
        m_sda_low = ~b; waitc(H);
        m_scl_low = 1'b0; waitc(H);
        m_scl_low = 1'b1; waitc(2);
    endtask

    // Sends a byte; ack_lvl returns the SDA level seen in the ninth clock.
    task automatic put_byte(input logic [7:0] b, output bit ack_lvl);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        m_sda_low = 1'b0; waitc(H);
        m_scl_low = 1'b0; waitc(H / 2);
        ack_lvl = sda_line;
        waitc(H / 2);
        m_scl_low = 1'b1; waitc(H);
    endtask

    // Receives a byte and answers with ACK (nack=0) or NACK (nack=1).
    task automatic get_byte(input bit nack, output logic [7:0] b, output bit ninth);
        m_sda_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            waitc(H);
            m_scl_low = 1'b0; waitc(H / 2);
            b[i] = sda_line;
            waitc(H / 2);
            m_scl_low = 1'b1; waitc(2);
        end
        m_sda_low = ~nack; waitc(H);
        m_scl_low = 1'b0; waitc(H / 2);
        ninth = sda_line;
        waitc(H / 2);
        m_scl_low = 1'b1; waitc(2);
        m_sda_low = 1'b0; waitc(H);
    endtask

    // ---- host model ----
    task automatic host_read(output logic [7:0] d);
        @(negedge clk); d = host_rdata; host_rd_en = 1'b1;
        @(negedge clk); host_rd_en = 1'b0;
        waitc(2);
    endtask

    task automatic host_write(input logic [7:0] d);
        @(negedge clk); host_wdata = d; host_wr_en = 1'b1;
        @(negedge clk); host_wr_en = 1'b0;
        waitc(2);
    endtask

    task automatic set_mode(input bit v);
        @(negedge clk); mode_tx = v; mode_we = 1'b1;
        @(negedge clk); mode_we = 1'b0;
    endtask

    task automatic set_ackdis(input bit v);
        @(negedge clk); ackdis_val = v; ackdis_we = 1'b1;
        @(negedge clk); ackdis_we = 1'b0;
    endtask

    function automatic logic [7:0] tx_val(input int k);
        return 8'((k * 37 + 5) & 255);
    endfunction

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] d;
        bit a;
        bit ninth;
        waitc(5);
        rst_n = 1'b1;
        waitc(3);

        // R1: reset state
        chk(scl_oe == 0 && sda_oe == 0, "R1 lines released", {scl_oe, sda_oe}, 0);
        chk(irq == 0 && addr_hit == 0, "R1 flags clear", {irq, addr_hit}, 0);
        chk(tx_mode == 0 && ack_dis == 0, "R1 controls clear", {tx_mode, ack_dis}, 0);

        // R2 / R3: sweep every 7-bit address
        for (int ad = 0; ad < 128; ad++) begin
            bus_start();
            put_byte({7'(ad), 1'b0}, a);
            if (7'(ad) == OWN) begin
                chk(a == 0, "R2 address ack", a, 0);
                chk(addr_hit && irq && scl_oe, "R2 hit/irq/hold", {addr_hit, irq, scl_oe}, 7);
                chk(rw_bit == 0, "R2 rw bit write", rw_bit, 0);
                waitc(20);
                chk(scl_oe == 1, "R4 hold persists", scl_oe, 1);
                host_read(d);
                chk(scl_oe == 0 && irq == 0 && addr_hit == 0, "R4 dummy read frees",
                    {scl_oe, irq, addr_hit}, 0);
            end else begin
                chk(a == 1, "R3 no ack", a, 1);
                chk(addr_hit == 0 && scl_oe == 0, "R3 no hold", {addr_hit, scl_oe}, 0);
                put_byte(8'h00, a);
                chk(a == 1 && scl_oe == 0, "R3 later byte ignored", {a, scl_oe}, 2);
            end
            bus_stop();
        end

        // R5 / R6: receive every byte value, ack disabled on some
        bus_start();
        put_byte({OWN, 1'b0}, a);
        host_read(d);
        for (int v = 0; v < 256; v++) begin
            bit dis;
            dis = (v % 16) == 15;
            set_ackdis(dis);
            put_byte(8'(v), a);
            chk(a == dis, "R6 ninth-clock ack", a, int'(dis));
            chk(scl_oe && irq, "R5 hold after byte", {scl_oe, irq}, 3);
            host_read(d);
            chk(d == 8'(v), "R5 received byte", d, v);
            chk(scl_oe == 0, "R4 read frees", scl_oe, 0);
        end
        set_ackdis(1'b0);
        bus_stop();

        // R7 / R8: transmit sequence ending with NACK
        bus_start();
        put_byte({OWN, 1'b1}, a);
        chk(a == 0 && rw_bit == 1, "R2 read address", {a, rw_bit}, 1);
        set_mode(1'b1);
        host_write(tx_val(0));
        chk(scl_oe == 0, "R4 write frees", scl_oe, 0);
        for (int k = 0; k < 64; k++) begin
            bit last;
            last = (k == 63);
            get_byte(last, d, ninth);
            chk(d == tx_val(k), "R7 sent byte", d, tx_val(k));
            chk(rx_ack == last, "R8 sampled ack", rx_ack, int'(last));
            chk(scl_oe && irq, "R8 hold after ack", {scl_oe, irq}, 3);
            if (last) begin
                chk(ninth == 1, "R7 SDA free on ninth clock", ninth, 1);
                set_mode(1'b0);
                host_read(d);
                chk(scl_oe == 0 && tx_mode == 0, "R4 dummy read after NACK",
                    {scl_oe, tx_mode}, 0);
            end else begin
                host_write(tx_val(k + 1));
            end
        end
        bus_stop();
        chk(sda_oe == 0 && scl_oe == 0, "R9 idle after stop", {sda_oe, scl_oe}, 0);

        // R9: STOP in the middle of a received byte with mode set
        bus_start();
        put_byte({OWN, 1'b0}, a);
        host_read(d);
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
        set_mode(1'b1);
        chk(tx_mode == 1, "R9 mode written", tx_mode, 1);
        bus_stop();
        waitc(4);
        chk(tx_mode == 0, "R9 stop clears mode", tx_mode, 0);
        chk(scl_oe == 0 && sda_oe == 0 && irq == 0, "R9 stop idles",
            {scl_oe, sda_oe, irq}, 0);

        // R10: repeated START from write into read
        bus_start();
        put_byte({OWN, 1'b0}, a);
        host_read(d);
        put_byte(8'h3C, a);
        chk(a == 0, "R10 data ack before restart", a, 0);
        host_read(d);
        chk(d == 8'h3C, "R10 byte before restart", d, 8'h3C);
        bus_start();
        put_byte({OWN, 1'b1}, a);
        chk(a == 0 && rw_bit == 1 && addr_hit == 1, "R10 restart matched",
            {a, rw_bit, addr_hit}, 3);
        set_mode(1'b1);
        host_write(8'hA5);
        get_byte(1'b1, d, ninth);
        chk(d == 8'hA5, "R10 byte after restart", d, 8'hA5);
        chk(rx_ack == 1, "R8 NACK after restart", rx_ack, 1);
        set_mode(1'b0);
        host_read(d);
        bus_stop();
        chk(scl_oe == 0 && sda_oe == 0, "R11 lines free at end", {scl_oe, sda_oe}, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule